// File: doc/BRIEF.md
# Checkpointed Register File with Single-Cycle Rollback

This block is a 16-entry, 32-bit register file. It has one write port and two asynchronous read ports, and it can roll back to a saved state. Each active register has a shadow copy behind it. When a transaction opens, the block copies the whole file into the shadow bank in one clock edge and latches a handler address. Any register writes made during the transaction change only the active bank. On an abort, every active register takes its shadow value in one edge. The block then presents the stored handler address on a one-cycle redirect pulse and records why the transaction failed. A commit closes the transaction and keeps the speculative contents.

The control is a two-state machine. `ST_IDLE` means no transaction is open, and `ST_TXN` means a transaction is open. The transitions are:
- BEGIN: `ST_IDLE` to `ST_TXN` on a checkpoint request.
- COMMIT: `ST_TXN` to `ST_IDLE` on a commit request without an abort.
- ROLLBACK: `ST_TXN` to `ST_IDLE` on an abort request.

Every other combination keeps the current state. A checkpoint in `ST_TXN` and a commit or abort in `ST_IDLE` are ignored. Instruction decode and memory-side conflict tracking sit outside the block; they drive the request inputs.

Top module: `ckpt_regfile`

## Requirements
- R1: After reset all 16 registers read 0, `txn_active` is 0, `abort_status` is 0 and `redirect_valid` is 0.
- R2: A write with `wr_en` high updates register `wr_addr` at the clock edge. Both read ports show the active contents of their addressed register combinationally.
- R3: A checkpoint in `ST_IDLE` takes the BEGIN transition, so `txn_active` is 1 after the edge. It snapshots the register contents as they were before that edge, so a write in the same cycle lands only in the active bank. It also latches `ckpt_addr` and clears `abort_status` to 0.
- R4: A checkpoint in `ST_TXN` is ignored. The snapshot and the latched handler address keep their values.
- R5: An abort in `ST_TXN` takes the ROLLBACK transition. All 16 registers read their snapshot values after that single edge.
- R6: On ROLLBACK, `abort_status` takes `abort_cause`, encoded as 0 none, 1 memory conflict, 2 buffer overflow, 3 software abort and 4 interrupt. It then holds that value until the next accepted checkpoint.
- R7: In the cycle after a ROLLBACK edge, `redirect_valid` is 1 for exactly one cycle and `redirect_addr` equals the address latched at BEGIN.
- R8: A commit in `ST_TXN` takes the COMMIT transition. Registers keep their speculative values, no redirect occurs and `abort_status` is unchanged.
- R9: A commit or abort in `ST_IDLE` has no effect on registers, state, status or redirect.
- R10: A write that coincides with a ROLLBACK is dropped, so the target register reads its snapshot value.
- R11: Abort and commit together in `ST_TXN` act as an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Write register index |
| wr_data | input | 32 | Write data |
| rd_addr_a | input | 4 | Read port A index |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 4 | Read port B index |
| rd_data_b | output | 32 | Read port B data |
| ckpt_req | input | 1 | Open a transaction and snapshot the file |
| ckpt_addr | input | 32 | Handler address latched at checkpoint |
| commit_req | input | 1 | Close the transaction and keep its results |
| abort_req | input | 1 | Roll back the transaction |
| abort_cause | input | 3 | Reason code recorded on rollback |
| txn_active | output | 1 | High while in `ST_TXN` |
| abort_status | output | 3 | Last recorded abort reason |
| redirect_valid | output | 1 | One-cycle pulse after rollback |
| redirect_addr | output | 32 | Latched handler address |

## Verification
The cases hardest to reach from the ports are collisions on the same edge. A write can meet a checkpoint, where the snapshot must miss the write. A write can meet an abort, where the write must vanish. A nested checkpoint carries a different handler address, and the old address must survive. The stimulus drives these requests together in the same cycle. For each collision it first writes values that differ in every register, so a wrong snapshot or a leaked write shows in a full read-back over both ports.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
    localparam int CAUSE_W = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE      = 3'd0,
        CAUSE_CONFLICT  = 3'd1,
        CAUSE_OVERFLOW  = 3'd2,
        CAUSE_SOFTWARE  = 3'd3,
        CAUSE_INTERRUPT = 3'd4
    } abort_cause_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_TXN  = 1'b1
    } txn_state_e;
endpackage

// File: rtl/ckpt_ctrl.sv
module ckpt_ctrl
    import ckpt_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ckpt_req,
    input  logic [PC_W-1:0]    ckpt_addr,
    input  logic               commit_req,
    input  logic               abort_req,
    input  logic [CAUSE_W-1:0] abort_cause,
    output logic               snap_en,
    output logic               restore_en,
    output logic               txn_active,
    output logic [CAUSE_W-1:0] status,
    output logic               redirect_valid,
    output logic [PC_W-1:0]    redirect_addr
);
    txn_state_e         state_q, state_d;
    logic [PC_W-1:0]    handler_q;
    logic [CAUSE_W-1:0] status_q;
    logic               redir_q;

    // next-state logic: BEGIN, COMMIT, ROLLBACK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ckpt_req) state_d = ST_TXN;
            ST_TXN:  if (abort_req || commit_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // per-state control outputs
    always_comb begin
        snap_en    = 1'b0;
        restore_en = 1'b0;
        txn_active = 1'b0;
        unique case (state_q)
            ST_IDLE: snap_en = ckpt_req;
            ST_TXN: begin
                txn_active = 1'b1;
                restore_en = abort_req;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            handler_q <= '0;
            status_q  <= CAUSE_NONE;
            redir_q   <= 1'b0;
        end else begin
            redir_q <= restore_en;
            if (snap_en) begin
                handler_q <= ckpt_addr;
                status_q  <= CAUSE_NONE;
            end
            if (restore_en) status_q <= abort_cause;
        end
    end

    assign status         = status_q;
    assign redirect_valid = redir_q;
    assign redirect_addr  = handler_q;
endmodule

// File: rtl/ckpt_store.sv
module ckpt_store #(
    parameter int NREGS  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              snap_en,
    input  logic              restore_en,
    input  logic [IDX_W-1:0]  rd_addr_a,
    input  logic [IDX_W-1:0]  rd_addr_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);
    logic [DATA_W-1:0] act_q [NREGS];
    logic [DATA_W-1:0] shd_q [NREGS];
    logic [NREGS-1:0]  wsel;

    // per-entry write select; rollback suppresses writes
    for (genvar g = 0; g < NREGS; g++) begin : g_wsel
        assign wsel[g] = wr_en && !restore_en && (wr_addr == IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                act_q[i] <= '0;
                shd_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                if (restore_en)   act_q[i] <= shd_q[i];
                else if (wsel[i]) act_q[i] <= wr_data;
                if (snap_en)      shd_q[i] <= act_q[i];
            end
        end
    end

    assign rd_data_a = act_q[rd_addr_a];
    assign rd_data_b = act_q[rd_addr_b];
endmodule

// File: rtl/ckpt_regfile.sv
module ckpt_regfile
    import ckpt_pkg::*;
#(
    parameter int NREGS  = 16,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]   rd_addr_a,
    output logic [DATA_W-1:0]  rd_data_a,
    input  logic [IDX_W-1:0]   rd_addr_b,
    output logic [DATA_W-1:0]  rd_data_b,
    input  logic               ckpt_req,
    input  logic [PC_W-1:0]    ckpt_addr,
    input  logic               commit_req,
    input  logic               abort_req,
    input  logic [CAUSE_W-1:0] abort_cause,
    output logic               txn_active,
    output logic [CAUSE_W-1:0] abort_status,
    output logic               redirect_valid,
    output logic [PC_W-1:0]    redirect_addr
);
    logic snap_en, restore_en;

    ckpt_ctrl #(.PC_W(PC_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .ckpt_req       (ckpt_req),
        .ckpt_addr      (ckpt_addr),
        .commit_req     (commit_req),
        .abort_req      (abort_req),
        .abort_cause    (abort_cause),
        .snap_en        (snap_en),
        .restore_en     (restore_en),
        .txn_active     (txn_active),
        .status         (abort_status),
        .redirect_valid (redirect_valid),
        .redirect_addr  (redirect_addr)
    );

    ckpt_store #(.NREGS(NREGS), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .snap_en    (snap_en),
        .restore_en (restore_en),
        .rd_addr_a  (rd_addr_a),
        .rd_addr_b  (rd_addr_b),
        .rd_data_a  (rd_data_a),
        .rd_data_b  (rd_data_b)
    );
endmodule

// File: rtl/ckpt_regfile_chk.sv
module ckpt_regfile_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ckpt_req,
    input logic            commit_req,
    input logic            abort_req,
    input logic [2:0]      abort_cause,
    input logic            txn_active,
    input logic [2:0]      abort_status,
    input logic            redirect_valid,
    input logic [PC_W-1:0] redirect_addr
);
    assert_begin_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ckpt_req && !txn_active) |=> (txn_active && abort_status == 3'd0));

    assert_nested_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ckpt_req && txn_active && !abort_req && !commit_req) |=> (txn_active && $stable(redirect_addr)));

    assert_rollback_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && txn_active) |=> !txn_active);

    assert_cause_recorded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && txn_active) |=> (abort_status == $past(abort_cause)));

    assert_status_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ckpt_req && !txn_active) && !(abort_req && txn_active)) |=> $stable(abort_status));

    assert_redirect_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> $past(abort_req && txn_active));

    assert_redirect_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);

    assert_commit_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && !abort_req && txn_active) |=> (!txn_active && !redirect_valid));

    assert_idle_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!txn_active && !ckpt_req) |=> (!txn_active && !redirect_valid));

    assert_abort_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && commit_req && txn_active) |=> redirect_valid);
endmodule

bind ckpt_regfile ckpt_regfile_chk #(.PC_W(PC_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ckpt_req       (ckpt_req),
    .commit_req     (commit_req),
    .abort_req      (abort_req),
    .abort_cause    (abort_cause),
    .txn_active     (txn_active),
    .abort_status   (abort_status),
    .redirect_valid (redirect_valid),
    .redirect_addr  (redirect_addr)
);

// File: tb/ckpt_regfile_test.sv
module ckpt_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr_a = '0, rd_addr_b = '0;
    logic [31:0] rd_data_a, rd_data_b;
    logic        ckpt_req = 1'b0;
    logic [31:0] ckpt_addr = '0;
    logic        commit_req = 1'b0, abort_req = 1'b0;
    logic [2:0]  abort_cause = '0;
    logic        txn_active;
    logic [2:0]  abort_status;
    logic        redirect_valid;
    logic [31:0] redirect_addr;

    int tests = 0;
    int fails = 0;
    logic [31:0] exp_reg [16];
    logic [31:0] exp_snap [16];
    logic        model_txn = 1'b0;

    always #10 clk = ~clk;

    ckpt_regfile uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a), .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .ckpt_req(ckpt_req), .ckpt_addr(ckpt_addr), .commit_req(commit_req),
        .abort_req(abort_req), .abort_cause(abort_cause), .txn_active(txn_active),
        .abort_status(abort_status), .redirect_valid(redirect_valid), .redirect_addr(redirect_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock with the given requests; inputs applied at negedge, sampled 1ns after posedge
    task automatic step(input logic we, input logic [3:0] wa, input logic [31:0] wd,
                        input logic ck, input logic [31:0] ca, input logic cm,
                        input logic ab, input logic [2:0] cause);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        ckpt_req = ck; ckpt_addr = ca; commit_req = cm;
        abort_req = ab; abort_cause = cause;
        @(posedge clk);
        #1;
        wr_en = 1'b0; ckpt_req = 1'b0; commit_req = 1'b0; abort_req = 1'b0;
        // bench model from the requirements
        if (!model_txn) begin
            if (ck) begin
                for (int i = 0; i < 16; i++) exp_snap[i] = exp_reg[i];
                model_txn = 1'b1;
            end
            if (we) exp_reg[wa] = wd;
        end else if (ab) begin
            for (int i = 0; i < 16; i++) exp_reg[i] = exp_snap[i];
            model_txn = 1'b0;
        end else begin
            if (we) exp_reg[wa] = wd;
            if (cm) model_txn = 1'b0;
        end
    endtask

    task automatic idle();
        step(1'b0, 4'd0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0, 3'd0);
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < 16; i++) begin
            rd_addr_a = 4'(i);
            rd_addr_b = 4'(15 - i);
            #1;
            chk(req, rd_data_a, exp_reg[i]);
            chk(req, rd_data_b, exp_reg[15 - i]);
        end
    endtask

    task automatic t_reset();
        chk("R1 txn", {31'd0, txn_active}, 32'd0);
        chk("R1 status", {29'd0, abort_status}, 32'd0);
        chk("R1 redirect", {31'd0, redirect_valid}, 32'd0);
        check_regs("R1 regs");
    endtask

    task automatic t_write_read();
        for (int i = 0; i < 16; i++)
            step(1'b1, 4'(i), 32'hA000_0000 + 32'(i) * 32'h111, 1'b0, 32'd0, 1'b0, 1'b0, 3'd0);
        check_regs("R2 write/read");
    endtask

    task automatic t_ckpt_abort();
        // checkpoint with a same-cycle write to r3: snapshot must hold the old r3
        step(1'b1, 4'd3, 32'h0000_DEAD, 1'b1, 32'h0000_4000, 1'b0, 1'b0, 3'd0);
        chk("R3 txn", {31'd0, txn_active}, 32'd1);
        chk("R3 status", {29'd0, abort_status}, 32'd0);
        check_regs("R3 active after begin");
        for (int i = 0; i < 16; i++)
            step(1'b1, 4'(i), ~(32'h5A5A_0000 + 32'(i)), 1'b0, 32'd0, 1'b0, 1'b0, 3'd0);
        step(1'b0, 4'd0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b1, 3'd1);
        chk("R7 redirect valid", {31'd0, redirect_valid}, 32'd1);
        chk("R7 redirect addr", redirect_addr, 32'h0000_4000);
        chk("R6 status conflict", {29'd0, abort_status}, 32'd1);
        chk("R5 txn", {31'd0, txn_active}, 32'd0);
        check_regs("R5 restore");
        idle();
        chk("R7 pulse ends", {31'd0, redirect_valid}, 32'd0);
        idle(); idle();
        chk("R6 status held", {29'd0, abort_status}, 32'd1);
    endtask

    task automatic t_commit();
        step(1'b0, 4'd0, 32'd0, 1'b1, 32'h0000_5000, 1'b0, 1'b0, 3'd0);
        chk("R6 cleared by checkpoint", {29'd0, abort_status}, 32'd0);
        step(1'b1, 4'd7, 32'h0000_0077, 1'b0, 32'd0, 1'b0, 1'b0, 3'd0);
        step(1'b0, 4'd0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b0, 3'd0);
        chk("R8 txn", {31'd0, txn_active}, 32'd0);
        chk("R8 no redirect", {31'd0, redirect_valid}, 32'd0);
        chk("R8 status", {29'd0, abort_status}, 32'd0);
        check_regs("R8 kept");
        // abort and commit while idle: no effect
        step(1'b0, 4'd0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b1, 3'd2);
        chk("R9 abort idle redirect", {31'd0, redirect_valid}, 32'd0);
        chk("R9 abort idle status", {29'd0, abort_status}, 32'd0);
        step(1'b0, 4'd0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b0, 3'd0);
        chk("R9 commit idle txn", {31'd0, txn_active}, 32'd0);
        check_regs("R9 regs");
    endtask

    task automatic t_nested();
        step(1'b0, 4'd0, 32'd0, 1'b1, 32'h0000_6000, 1'b0, 1'b0, 3'd0);
        step(1'b1, 4'd1, 32'h0000_0011, 1'b0, 32'd0, 1'b0, 1'b0, 3'd0);
        step(1'b0, 4'd0, 32'd0, 1'b1, 32'h0000_7000, 1'b0, 1'b0, 3'd0);
        chk("R4 still active", {31'd0, txn_active}, 32'd1);
        chk("R4 addr kept", redirect_addr, 32'h0000_6000);
        step(1'b1, 4'd1, 32'h0000_0022, 1'b0, 32'd0, 1'b0, 1'b0, 3'd0);
        step(1'b0, 4'd0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b1, 3'd3);
        chk("R4 redirect addr", redirect_addr, 32'h0000_6000);
        chk("R6 status software", {29'd0, abort_status}, 32'd3);
        check_regs("R4 first snapshot");
    endtask

    task automatic t_write_abort();
        step(1'b0, 4'd0, 32'd0, 1'b1, 32'h0000_8000, 1'b0, 1'b0, 3'd0);
        step(1'b1, 4'd5, 32'h1234_5678, 1'b0, 32'd0, 1'b0, 1'b0, 3'd0);
        step(1'b1, 4'd5, 32'h8765_4321, 1'b0, 32'd0, 1'b0, 1'b1, 3'd4);
        chk("R10 status interrupt", {29'd0, abort_status}, 32'd4);
        rd_addr_a = 4'd5; #1;
        chk("R10 write dropped", rd_data_a, exp_reg[5]);
        check_regs("R10 regs");
    endtask

    task automatic t_abort_commit();
        step(1'b0, 4'd0, 32'd0, 1'b1, 32'h0000_9000, 1'b0, 1'b0, 3'd0);
        step(1'b1, 4'd9, 32'hCAFE_0009, 1'b0, 32'd0, 1'b0, 1'b0, 3'd0);
        step(1'b0, 4'd0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b1, 3'd2);
        chk("R11 redirect", {31'd0, redirect_valid}, 32'd1);
        chk("R11 addr", redirect_addr, 32'h0000_9000);
        chk("R11 status overflow", {29'd0, abort_status}, 32'd2);
        check_regs("R11 restored");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            exp_reg[i] = '0;
            exp_snap[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_write_read();
        t_ckpt_abort();
        t_commit();
        t_nested();
        t_write_abort();
        t_abort_commit();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #4000000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule